// File: doc/BRIEF.md
# I2C Command Tag Stream Generator

This block turns one I2C message request into the byte stream that an I2C master engine reads from its output FIFO. A request carries a target address, a read/write flag, a ten-bit-address flag and a total byte count. Write payload arrives one byte at a time on a valid/ready input. The generator cuts the message into blocks of at most `BLK_BYTES` bytes. It puts a short header of command tags in front of each block, so that long messages run on the bus with no stop condition between blocks.

The header and payload bytes form one continuous stream. That stream is packed little-endian into 32-bit words, and each word goes downstream with a byte-count side signal under valid/ready. When a request is accepted, the block also reports two values. The first is the total transmit tag length the engine should be programmed with. The second is whether the message fits FIFO mode or needs block mode. `BLK_BYTES` must be a power of two no larger than 256, and `LEN_W` must be wider than its log2.

Top module: `i2c_tag_stream`

## Requirements
- R1: A request with zero length is rejected. `req_err` pulses high for exactly the one cycle after the accepting edge, no word is emitted, and `req_ready` stays high.
- R2: A request is accepted only while `req_ready` is high. `req_ready` drops at the accepting edge and rises again at the edge where the last word of the message is taken downstream. A request presented while busy has no effect on the stream and raises no error.
- R3: The message is split into ceil(len/BLK_BYTES) blocks. Each block carries min(remaining, BLK_BYTES) payload bytes.
- R4: Only the first block's header begins with tag 0x81, followed by the address byte {addr[6:0], rd}. In ten-bit mode a third byte follows, holding bits 10:8 of {addr[9:0], rd} in its bits 2:0, with zeros above.
- R5: Every block header then carries an opcode. It is 0x82 for write and 0x85 for read, except on the last block, where it is 0x83 for write with stop and 0x87 for read with stop.
- R6: The opcode is followed by a length byte equal to the block's payload count, where a count of exactly BLK_BYTES is encoded as 0x00.
- R7: For a write, the block's payload bytes follow its header, consumed in order from `wr_data`. For a read, only header bytes are emitted and `wr_ready` stays low.
- R8: Stream bytes are packed little-endian, with the first byte in bits 7:0. Header and payload bytes share words. Every word but the last of a message carries 4 bytes.
- R9: `out_bytes` is always 1 to 4. Byte lanes of a partial final word at and above `out_bytes` are zero.
- R10: From acceptance until the next acceptance, `tag_len` equals 4 + 2*(blocks-1).
- R11: From acceptance until the next acceptance, `blk_mode` is 1 when `tag_len` plus the write payload length (0 for reads) is at least `FIFO_DEPTH`, and 0 otherwise.
- R12: While `out_valid` is high and `out_ready` low, `out_valid`, `out_data` and `out_bytes` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Message request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | 10 | Target address (low 7 bits used in seven-bit mode) |
| req_rd | input | 1 | 1 = read message, 0 = write |
| req_ten | input | 1 | Ten-bit addressing |
| req_len | input | LEN_W | Message payload length in bytes |
| req_err | output | 1 | One-cycle pulse: zero-length request rejected |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Payload byte present |
| wr_ready | output | 1 | Payload byte taken this cycle |
| out_data | output | 32 | Packed stream word |
| out_bytes | output | 3 | Valid bytes in `out_data`, 1 to 4 |
| out_valid | output | 1 | Word present |
| out_ready | input | 1 | Downstream takes the word |
| tag_len | output | LEN_W+2 | Transmit tag length of the current message |
| blk_mode | output | 1 | 1 = block mode, 0 = FIFO mode |

## Verification
The bench builds the generator with `LEN_W` = 6, `BLK_BYTES` = 4 and `FIFO_DEPTH` = 14. Four-byte blocks mean that a sweep of lengths 0 to 30, plus the maximum 63, covers single-block, multi-block, exact-multiple and partial-last-block messages. It also places header bytes at every word lane offset, in both address modes and both directions. With a depth of 14, writes of 7 and 8 bytes sit on either side of the FIFO/block mode threshold, and so do reads of 20 and 21 bytes. Pseudo-random stalls on both the payload input and the output exercise the backpressure hold and the stalled header path.

// File: rtl/i2c_tag_stream.sv
module i2c_tag_stream #(
  parameter int LEN_W      = 16,
  parameter int BLK_BYTES  = 256,
  parameter int FIFO_DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [9:0]       req_addr,
  input  logic             req_rd,
  input  logic             req_ten,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_err,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [31:0]      out_data,
  output logic [2:0]       out_bytes,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LEN_W+1:0] tag_len,
  output logic             blk_mode
);
  localparam int BLK_W = $clog2(BLK_BYTES);
  localparam logic [LEN_W-1:0] BLK_L = LEN_W'(BLK_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA, S_DRAIN} st_t;
  st_t state;

  logic [LEN_W-1:0] rem, dcnt;
  logic             first, rd_q, ten_q;
  logic [10:0]      sadr;
  logic [2:0]       hidx;
  logic [23:0]      acc;
  logic [1:0]       cnt;

  wire [LEN_W-1:0] blk_len  = (rem > BLK_L) ? BLK_L : rem;
  wire             last_blk = rem <= BLK_L;
  wire [2:0]       hoff     = first ? (ten_q ? 3'd3 : 3'd2) : 3'd0;
  wire             hdr_end  = hidx == hoff + 3'd1;
  wire [2:0]       rel      = hidx - hoff;
  wire [7:0]       opcode   = {4'h8, last_blk ? (rd_q ? 4'h7 : 4'h3) : (rd_q ? 4'h5 : 4'h2)};
  wire [7:0]       lenbyte  = (blk_len == BLK_L) ? 8'h00 : 8'(blk_len);

  logic [7:0] hbyte;
  always_comb begin
    if (first && hidx == 3'd0)                hbyte = 8'h81;
    else if (first && hidx == 3'd1)           hbyte = sadr[7:0];
    else if (first && ten_q && hidx == 3'd2)  hbyte = {5'b0, sadr[10:8]};
    else if (rel == 3'd0)                     hbyte = opcode;
    else                                      hbyte = lenbyte;
  end

  wire        in_data   = state == S_DATA;
  wire        byte_v    = (state == S_HDR) || (in_data && wr_valid);
  wire [7:0]  byte_d    = in_data ? wr_data : hbyte;
  wire        byte_last = in_data ? (rem == LEN_W'(1)) : (rd_q && last_blk && hdr_end);
  wire        slot_free = !out_valid || out_ready;
  wire        take      = byte_v && slot_free;
  wire        flush     = take && (cnt == 2'd3 || byte_last);
  wire [31:0] word_now  = {8'h00, acc} | (32'(byte_d) << {cnt, 3'b000});

  assign req_ready = state == S_IDLE;
  assign wr_ready  = in_data && slot_free;

  wire [LEN_W:0]   nblk    = ({1'b0, req_len} + (LEN_W+1)'(BLK_BYTES - 1)) >> BLK_W;
  wire [LEN_W+1:0] tl_calc = {nblk, 1'b0} + (LEN_W+2)'(2);
  wire [LEN_W+2:0] tot     = {1'b0, tl_calc} + (req_rd ? '0 : (LEN_W+3)'(req_len));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_bytes <= 3'd0;
      acc       <= '0;
      cnt       <= 2'd0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        if (flush) begin
          out_data  <= word_now;
          out_bytes <= {1'b0, cnt} + 3'd1;
          out_valid <= 1'b1;
          acc       <= '0;
          cnt       <= 2'd0;
        end else begin
          acc <= word_now[23:0];
          cnt <= cnt + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      req_err  <= 1'b0;
      rem      <= '0;
      dcnt     <= '0;
      first    <= 1'b0;
      rd_q     <= 1'b0;
      ten_q    <= 1'b0;
      sadr     <= '0;
      hidx     <= 3'd0;
      tag_len  <= '0;
      blk_mode <= 1'b0;
    end else begin
      req_err <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          if (req_len == '0) req_err <= 1'b1;
          else begin
            rem      <= req_len;
            first    <= 1'b1;
            rd_q     <= req_rd;
            ten_q    <= req_ten;
            sadr     <= {req_addr, req_rd};
            hidx     <= 3'd0;
            tag_len  <= tl_calc;
            blk_mode <= 32'(tot) >= 32'(FIFO_DEPTH);
            state    <= S_HDR;
          end
        end
        S_HDR: if (take) begin
          if (hdr_end) begin
            first <= 1'b0;
            hidx  <= 3'd0;
            if (rd_q) begin
              rem   <= rem - blk_len;
              state <= last_blk ? S_DRAIN : S_HDR;
            end else begin
              dcnt  <= blk_len;
              state <= S_DATA;
            end
          end else hidx <= hidx + 3'd1;
        end
        S_DATA: if (take) begin
          rem  <= rem - LEN_W'(1);
          dcnt <= dcnt - LEN_W'(1);
          if (rem == LEN_W'(1))       state <= S_DRAIN;
          else if (dcnt == LEN_W'(1)) state <= S_HDR;
        end
        default: if (out_valid && out_ready) state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tag_stream_chk.sv
module i2c_tag_stream_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        req_err,
  input logic        wr_ready,
  input logic [31:0] out_data,
  input logic [2:0]  out_bytes,
  input logic        out_valid,
  input logic        out_ready
);
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (req_ready && !out_valid)); // R1
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready); // R2
  AST_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !req_ready); // R7
  AST_BYTES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bytes >= 3'd1 && out_bytes <= 3'd4)); // R9
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bytes < 3'd4) |-> ((out_data >> {out_bytes, 3'b000}) == 32'd0)); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_bytes))); // R12
endmodule

bind i2c_tag_stream i2c_tag_stream_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_err(req_err),
  .wr_ready(wr_ready), .out_data(out_data), .out_bytes(out_bytes),
  .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/i2c_tag_stream_test.sv
module i2c_tag_stream_test;
  localparam int LW = 6, BB = 4, FD = 14;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_rd = 0, req_ten = 0, wr_valid = 0, out_ready = 0;
  logic [9:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [7:0] wr_data = '0;
  logic req_ready, req_err, wr_ready, out_valid, blk_mode;
  logic [31:0] out_data;
  logic [2:0] out_bytes;
  logic [LW+1:0] tag_len;

  int tests = 0, fails = 0;
  logic [15:0] lf = 16'hACE1;

  always #2.5 clk = ~clk;

  i2c_tag_stream #(.LEN_W(LW), .BLK_BYTES(BB), .FIFO_DEPTH(FD)) uut (.*);

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(int len, int i);
    return 8'(i * 13 + len * 3 + 1);
  endfunction

  task automatic step_lf();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic run_msg(input int len, input bit rd, input bit ten, input bit poke);
    logic [7:0] e[256];
    int kind[256];
    int n = 0, rem = len, di = 0, nb = 0, tl;
    bit frst = 1;
    logic [9:0] a = 10'((len * 37 + rd * 5 + ten * 3) & 10'h3ff);
    logic [10:0] sh = {a, rd};
    int got = 0, idx = 0, bad[4] = '{0, 0, 0, 0}, first_bad[4], act_bad[4];
    int pack_bad = 0, pad_bad = 0, hold_bad = 0, err_seen = 0, cyc = 0;
    bit held = 0;
    logic [31:0] hd;
    logic [2:0] hb;
    while (rem > 0) begin
      int bl = rem > BB ? BB : rem;
      nb++;
      if (frst) begin
        e[n] = 8'h81; kind[n++] = 0;
        e[n] = sh[7:0]; kind[n++] = 0;
        if (ten) begin e[n] = {5'b0, sh[10:8]}; kind[n++] = 0; end
      end
      e[n] = (rem <= BB) ? (rd ? 8'h87 : 8'h83) : (rd ? 8'h85 : 8'h82); kind[n++] = 1;
      e[n] = (bl == BB) ? 8'h00 : 8'(bl); kind[n++] = 2;
      if (!rd) for (int j = 0; j < bl; j++) begin e[n] = byte_of(len, di++); kind[n++] = 3; end
      rem -= bl; frst = 0;
    end
    tl = 2 * nb + 2;

    @(negedge clk);
    req_valid = 1; req_len = LW'(len); req_rd = rd; req_ten = ten; req_addr = a;
    #1;
    chk(req_ready === 1'b1, "R2 ready before accept", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    if (len == 0) begin
      chk(req_err === 1'b1, "R1 error pulse", req_err, 1);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (k == 0) chk(req_err === 1'b0, "R1 error one cycle", req_err, 0);
        chk(!out_valid && req_ready, "R1 no output, stays ready", {out_valid, req_ready}, 1);
      end
      return;
    end
    chk(req_ready === 1'b0, "R2 busy after accept", req_ready, 0);
    chk(req_err === 1'b0, "R1 no error on nonzero", req_err, 0);
    chk(tag_len == (LW+2)'(tl), "R10 tag length", tag_len, tl);
    chk(blk_mode == ((tl + (rd ? 0 : len)) >= FD), "R11 mode", blk_mode,
        (tl + (rd ? 0 : len)) >= FD);
    for (int k = 0; k < 4; k++) first_bad[k] = -1;

    while (cyc < 3000) begin
      cyc++;
      step_lf();
      if (poke) begin req_valid = 1; req_len = '0; end
      wr_valid = (idx < len) && (lf[2] | lf[5]);
      wr_data = byte_of(len, idx);
      out_ready = lf[0] | lf[7];
      #1;
      if (req_err) err_seen++;
      if (wr_valid && wr_ready) idx++;
      if (held) begin
        if (!(out_valid && out_data == hd && out_bytes == hb)) hold_bad++;
      end
      held = 0;
      if (out_valid && !out_ready) begin held = 1; hd = out_data; hb = out_bytes; end
      if (out_valid && out_ready) begin
        for (int b = 0; b < 4; b++) begin
          if (b < int'(out_bytes)) begin
            if (got < n) begin
              if (out_data[b*8 +: 8] !== e[got]) begin
                if (first_bad[kind[got]] < 0) begin
                  first_bad[kind[got]] = e[got];
                  act_bad[kind[got]] = out_data[b*8 +: 8];
                end
                bad[kind[got]]++;
              end
            end
            got++;
          end else if (out_data[b*8 +: 8] !== 8'h00) pad_bad++;
        end
        if (out_bytes != 3'd4 && got < n) pack_bad++;
        if (out_bytes == 3'd0 || out_bytes > 3'd4) pad_bad++;
      end
      @(negedge clk);
      if (poke) req_valid = 0;
      if (req_ready && got >= n) break;
    end
    if (req_err) err_seen++;
    chk(req_ready === 1'b1, "R2 returns idle after last word", req_ready, 1);
    chk(got == n, "R3 stream byte count", got, n);
    chk(bad[0] == 0, "R4 start/address bytes", act_bad[0], first_bad[0]);
    chk(bad[1] == 0, "R5 opcode", act_bad[1], first_bad[1]);
    chk(bad[2] == 0, "R6 length byte", act_bad[2], first_bad[2]);
    chk(bad[3] == 0 && idx == (rd ? 0 : len), "R7 payload bytes", idx, rd ? 0 : len);
    chk(pack_bad == 0, "R8 non-final word full", pack_bad, 0);
    chk(pad_bad == 0, "R9 padding and byte count", pad_bad, 0);
    chk(hold_bad == 0, "R12 hold under backpressure", hold_bad, 0);
    if (poke) chk(err_seen == 0, "R2 request while busy ignored", err_seen, 0);
  endtask

  initial begin
    #900000;
    fails++; tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !out_valid && !wr_ready && !req_err, "R2 reset state",
        {req_ready, out_valid, wr_ready, req_err}, 4'b1000);
    for (int len = 0; len <= 31; len++) begin
      for (int rd = 0; rd < 2; rd++) begin
        for (int ten = 0; ten < 2; ten++) begin
          run_msg(len == 31 ? 63 : len, rd[0], ten[0], m[0]);
          m++;
        end
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule